// File: doc/BRIEF.md
# Four-Level Page Table Walker with Permission Check

This block turns a 48-bit virtual address into a 52-bit physical address. It walks four levels of translation tables that sit in ordinary memory and reads them through one memory port. The block checks every entry it fetches for presence. It checks the leaf entry's protection bits against the kind of access and the privilege mode of the requester. When the access is allowed and it changes the leaf entry's usage bits, the updated entry is written back to memory before the result is reported.

A requester loads the frame number of the top-level table into a root register. It then offers one translation at a time through a valid/ready handshake and waits for a one-cycle response. The response carries either the physical address or a fault code. Tables are 4 KB pages of 512 entries, each entry 8 bytes wide. The virtual address is cut into four 9-bit indices (bits 47:39, 38:30, 29:21 and 20:12, used in that order) and a 12-bit page offset.

Entry fields:

| Bit(s) | Meaning |
|---|---|
| 0 | present |
| 1 | writable |
| 2 | user-accessible (0 means supervisor only) |
| 5 | accessed |
| 6 | dirty |
| 51:12 | frame number |
| 63 | no-execute |

Access kinds: 0 is a read, 1 is a write, 2 is an instruction fetch. Fault codes: 0 is none, 1 is not-present, 2 is protection.

Top module: `ptw_top`

## Requirements
- R1: The walk issues exactly one read per level in level order. Level 0 reads address root_frame·4096 + index0·8. Each later level reads (frame of the previous entry)·4096 + its own index·8.
- R2: A permitted access answers with rsp_fault = 0 and rsp_paddr = {leaf frame (bits 51:12), virtual bits 11:0}.
- R3: An entry with bit 0 clear at any level ends the walk at once with rsp_fault = 1 and rsp_paddr = 0. No further table read is issued.
- R4: A write (kind 1) to a leaf whose bit 1 is clear answers rsp_fault = 2 and rsp_paddr = 0.
- R5: A fetch (kind 2) from a leaf whose bit 63 is set answers rsp_fault = 2. A read of the same leaf is permitted.
- R6: A user access (req_user = 1) to a leaf whose bit 2 is clear answers rsp_fault = 2. A supervisor access to the same leaf is permitted.
- R7: A permitted access whose leaf has bit 5 clear, or a permitted write whose leaf has bit 6 clear, causes exactly one memory write before the response. The write goes to the leaf's address, with bit 5 set, bit 6 set for a write, and all other bits unchanged.
- R8: No memory write occurs when the access faults, or when bits 5 and 6 already hold their required values.
- R9: req_ready is high only while no translation is in progress. rsp_valid is a single-cycle pulse, after which req_ready is high again.
- R10: A leaf entry with bit 0 clear reports fault code 1 even when the access also breaks its protection bits.
- R11: The root frame register resets to 0. A value loaded with root_we is used by every request accepted afterwards.
- R12: After reset req_ready = 1, rsp_valid = 0 and mem_req_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_we | input | 1 | Load enable for the root frame register |
| root_wdata | input | 40 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 48 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 52 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 not-present, 2 protection |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_we | output | 1 | 1 for the entry write-back |
| mem_req_wdata | output | 64 | Updated entry for the write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Entry read from memory |

## Verification
The assertions rely on three things about the memory side. It returns exactly one mem_rsp_valid pulse for each accepted read. It never returns one while no read is outstanding. It produces no response at all for a write. The assertions also assume that req_kind never takes the value 3.

The bench's memory model keeps to these rules. It stalls mem_req_ready at random and answers each accepted read once, after 0 to 2 idle cycles. It draws access kinds only from 0 to 2. It never offers a request except through the idle handshake.

// File: rtl/ptw_pkg.sv
// Shared encodings of the page table walker.
// Assumes 64-bit entries with the bit layout listed in the brief.
package ptw_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WB,
        ST_DONE
    } walk_st_e;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_RW      = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;
    localparam int BIT_NX      = 63;
endpackage

// File: rtl/ptw_index.sv
// Entry address generator: picks the index field for the current level
// and places it, scaled by the entry size, inside the table's page.
// Assumes the table spans exactly one page (IDX_W + log2(entry bytes) == OFF_W).
module ptw_index #(
    parameter int VA_W    = 48,
    parameter int PA_W    = 52,
    parameter int LEVELS  = 4,
    parameter int OFF_W   = 12,
    parameter int ENTRY_W = 64,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int IDX_W  = (VA_W - OFF_W) / LEVELS,
    localparam int FRM_W  = PA_W - OFF_W
) (
    input  logic [VA_W-OFF_W-1:0] vpn,
    input  logic [FRM_W-1:0]      base_frame,
    input  logic [LVL_W-1:0]      level,
    output logic [PA_W-1:0]       entry_addr
);
    localparam int ESH = $clog2(ENTRY_W / 8);

    logic [IDX_W-1:0] idx_tab [LEVELS];

    // Slice one index field per level, top level first.
    for (genvar l = 0; l < LEVELS; l++) begin : g_idx
        assign idx_tab[l] = vpn[IDX_W*(LEVELS-1-l) +: IDX_W];
    end

    // Combine the table page with the scaled index.
    always_comb begin
        entry_addr = {base_frame, {OFF_W{1'b0}}} | (PA_W'(idx_tab[level]) << ESH);
    end
endmodule

// File: rtl/ptw_perm.sv
// Leaf permission check and usage-bit update.
// Assumes kind is one of the three access encodings and the entry is present.
module ptw_perm #(
    parameter int ENTRY_W = 64
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [1:0]         kind,
    input  logic               user,
    output logic               prot_fault,
    output logic [ENTRY_W-1:0] new_entry,
    output logic               needs_wb
);
    import ptw_pkg::*;

    // Decide protection outcome and the entry value after this access.
    always_comb begin
        prot_fault = ((kind == ACC_WRITE) && !entry[BIT_RW]) ||
                     ((kind == ACC_FETCH) &&  entry[BIT_NX]) ||
                     (user && !entry[BIT_USER]);
        new_entry = entry;
        new_entry[BIT_ACC] = 1'b1;
        if (kind == ACC_WRITE) new_entry[BIT_DIRTY] = 1'b1;
        needs_wb = !prot_fault && (new_entry != entry);
    end
endmodule

// File: rtl/ptw_fsm.sv
// Walk sequencer: accepts one request while idle, reads one entry per
// level, stops on an absent entry, applies the leaf check, optionally
// writes the leaf back, then pulses the result.
// Assumes one memory response per accepted read and none for writes.
module ptw_fsm #(
    parameter int VA_W    = 48,
    parameter int PA_W    = 52,
    parameter int LEVELS  = 4,
    parameter int OFF_W   = 12,
    parameter int ENTRY_W = 64,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int FRM_W  = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [FRM_W-1:0]   root_frame,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic               mem_req_we,
    output logic [ENTRY_W-1:0] mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic               ent_present,
    input  logic [FRM_W-1:0]   ent_frame,
    input  logic [PA_W-1:0]    entry_addr,
    input  logic               prot_fault,
    input  logic [ENTRY_W-1:0] new_entry,
    input  logic               needs_wb,
    output logic [VA_W-1:0]    vaddr_q,
    output logic [1:0]         kind_q,
    output logic               user_q,
    output logic [FRM_W-1:0]   base_q,
    output logic [LVL_W-1:0]   level_q
);
    import ptw_pkg::*;

    walk_st_e           state;
    logic [PA_W-1:0]    leaf_addr_q;
    logic [ENTRY_W-1:0] wb_data_q;
    logic [PA_W-1:0]    paddr_q;
    flt_e               fault_q;

    // Advance the walk state and hold the per-walk context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            vaddr_q     <= '0;
            kind_q      <= '0;
            user_q      <= 1'b0;
            base_q      <= '0;
            level_q     <= '0;
            leaf_addr_q <= '0;
            wb_data_q   <= '0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    kind_q  <= req_kind;
                    user_q  <= req_user;
                    base_q  <= root_frame;
                    level_q <= '0;
                    state   <= ST_ISSUE;
                end
                ST_ISSUE: if (mem_req_ready) begin
                    leaf_addr_q <= entry_addr;
                    state       <= ST_WAIT;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        fault_q <= FLT_ABSENT;
                        paddr_q <= '0;
                        state   <= ST_DONE;
                    end else if (level_q != LVL_W'(LEVELS - 1)) begin
                        base_q  <= ent_frame;
                        level_q <= level_q + 1'b1;
                        state   <= ST_ISSUE;
                    end else if (prot_fault) begin
                        fault_q <= FLT_PROT;
                        paddr_q <= '0;
                        state   <= ST_DONE;
                    end else begin
                        fault_q   <= FLT_NONE;
                        paddr_q   <= {ent_frame, vaddr_q[OFF_W-1:0]};
                        wb_data_q <= new_entry;
                        state     <= needs_wb ? ST_WB : ST_DONE;
                    end
                end
                ST_WB: if (mem_req_ready) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive handshakes and memory request fields from the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        rsp_valid     = (state == ST_DONE);
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
        mem_req_valid = (state == ST_ISSUE) || (state == ST_WB);
        mem_req_we    = (state == ST_WB);
        mem_req_addr  = (state == ST_WB) ? leaf_addr_q : entry_addr;
        mem_req_wdata = wb_data_q;
    end

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    p_fault_addr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != FLT_NONE) |-> rsp_paddr == '0);

    p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_ACC]);

    p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we && (kind_q == ACC_WRITE) |-> mem_req_wdata[BIT_DIRTY]);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    p_absent_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) && mem_rsp_valid && !ent_present |=> rsp_valid && (rsp_fault == FLT_ABSENT));
endmodule

// File: rtl/ptw_top.sv
// Page table walker top: root frame register, entry address generator,
// leaf permission check and walk sequencer.
// Assumes a single requester and a memory port that answers reads in order.
module ptw_top #(
    parameter int VA_W    = 48,
    parameter int PA_W    = 52,
    parameter int LEVELS  = 4,
    parameter int OFF_W   = 12,
    parameter int ENTRY_W = 64,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int FRM_W  = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               root_we,
    input  logic [FRM_W-1:0]   root_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic               mem_req_we,
    output logic [ENTRY_W-1:0] mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_rdata
);
    import ptw_pkg::*;

    logic [FRM_W-1:0]   root_q;
    logic [VA_W-1:0]    vaddr_q;
    logic [1:0]         kind_q;
    logic               user_q;
    logic [FRM_W-1:0]   base_q;
    logic [LVL_W-1:0]   level_q;
    logic [PA_W-1:0]    entry_addr;
    logic               prot_fault;
    logic [ENTRY_W-1:0] new_entry;
    logic               needs_wb;

    // Hold the top-level table frame loaded by the requester.
    always_ff @(posedge clk) begin
        if (!rst_n)       root_q <= '0;
        else if (root_we) root_q <= root_wdata;
    end

    ptw_index #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)
    ) u_index (
        .vpn        (vaddr_q[VA_W-1:OFF_W]),
        .base_frame (base_q),
        .level      (level_q),
        .entry_addr (entry_addr)
    );

    ptw_perm #(.ENTRY_W(ENTRY_W)) u_perm (
        .entry      (mem_rsp_rdata),
        .kind       (kind_q),
        .user       (user_q),
        .prot_fault (prot_fault),
        .new_entry  (new_entry),
        .needs_wb   (needs_wb)
    );

    ptw_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_kind      (req_kind),
        .req_user      (req_user),
        .root_frame    (root_q),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_we    (mem_req_we),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_present   (mem_rsp_rdata[BIT_PRESENT]),
        .ent_frame     (mem_rsp_rdata[OFF_W +: FRM_W]),
        .entry_addr    (entry_addr),
        .prot_fault    (prot_fault),
        .new_entry     (new_entry),
        .needs_wb      (needs_wb),
        .vaddr_q       (vaddr_q),
        .kind_q        (kind_q),
        .user_q        (user_q),
        .base_q        (base_q),
        .level_q       (level_q)
    );

    p_idle_after_reset_r12: assert property (@(posedge clk)
        $past(!rst_n) |-> req_ready && !rsp_valid && !mem_req_valid);
endmodule

// File: tb/ptw_top_test.sv
module ptw_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [39:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [51:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_req_we;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;

    always #5 clk = ~clk;

    ptw_top uut (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int total = 0;
    int bad = 0;
    logic [63:0] mem [0:4095];
    logic [39:0] root_val = '0;

    // observed memory traffic of the current translation
    logic [51:0] obs_rd [0:7];
    int          obs_nrd;
    int          obs_nwb;
    logic [51:0] obs_wba;
    logic [63:0] obs_wbd;

    // expected results from the reference walk
    logic [51:0] exp_rd [0:3];
    int          exp_nrd;
    logic [1:0]  exp_f;
    logic [51:0] exp_pa;
    logic        exp_wb;
    logic [51:0] exp_wba;
    logic [63:0] exp_wbd;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Memory model: random ready stalls, 0..2 cycle read latency.
    task automatic responder();
        logic        hs = 1'b0;
        logic [51:0] hs_a = '0;
        logic        hs_we = 1'b0;
        logic [63:0] hs_d = '0;
        logic        rd_pend = 1'b0;
        int          rd_cnt = 0;
        logic [63:0] rd_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rd_pend) begin
                if (rd_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rd_data;
                    rd_pend = 1'b0;
                end else rd_cnt--;
            end
            if (hs) begin
                if (hs_we) begin
                    mem[hs_a[14:3]] = hs_d;
                    obs_nwb++;
                    obs_wba = hs_a;
                    obs_wbd = hs_d;
                end else begin
                    if (obs_nrd < 8) obs_rd[obs_nrd] = hs_a;
                    obs_nrd++;
                    rd_pend = 1'b1;
                    rd_cnt  = int'($urandom % 3);
                    rd_data = mem[hs_a[14:3]];
                end
            end
            mem_req_ready = rst_n && mem_req_valid && (($urandom % 4) != 0);
            hs    = mem_req_ready;
            hs_a  = mem_req_addr;
            hs_we = mem_req_we;
            hs_d  = mem_req_wdata;
        end
    endtask

    task automatic ref_walk(input logic [47:0] va, input logic [1:0] kd, input logic u);
        logic [51:0] base;
        logic [51:0] ea;
        logic [63:0] e;
        logic [63:0] ne;
        logic [8:0]  idx;
        base = {root_val, 12'h000};
        exp_nrd = 0; exp_f = 2'd0; exp_pa = '0; exp_wb = 1'b0; exp_wba = '0; exp_wbd = '0;
        for (int l = 0; l < 4; l++) begin
            idx = va[12 + 9*(3-l) +: 9];
            ea  = base | {40'd0, idx, 3'b000};
            exp_rd[l] = ea;
            exp_nrd++;
            e = mem[ea[14:3]];
            if (!e[0]) begin exp_f = 2'd1; return; end
            if (l < 3) base = {e[51:12], 12'h000};
            else begin
                if ((kd == 2'd1 && !e[1]) || (kd == 2'd2 && e[63]) || (u && !e[2])) begin
                    exp_f = 2'd2; return;
                end
                exp_pa = {e[51:12], va[11:0]};
                ne = e | 64'h20 | ((kd == 2'd1) ? 64'h40 : 64'h0);
                if (ne != e) begin exp_wb = 1'b1; exp_wba = ea; exp_wbd = ne; end
            end
        end
    endtask

    task automatic set_root(input logic [39:0] v);
        @(negedge clk);
        root_we = 1'b1; root_wdata = v;
        @(negedge clk);
        root_we = 1'b0;
        root_val = v;
    endtask

    task automatic do_txn(input logic [47:0] va, input logic [1:0] kd, input logic u, input string tag);
        int n;
        ref_walk(va, kd, u);
        obs_nrd = 0; obs_nwb = 0;
        @(negedge clk);
        chk("R9 idle ready", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_vaddr = va; req_kind = kd; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy", 64'(req_ready), 64'd0);
        n = 0;
        while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
        if (!rsp_valid) begin
            chk("R9 response timeout", 64'd0, 64'd1);
            return;
        end
        #1;
        chk({tag, " fault"}, 64'(rsp_fault), 64'(exp_f));
        chk({tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
        chk("R1 read count", 64'(obs_nrd), 64'(exp_nrd));
        for (int i = 0; i < exp_nrd && i < obs_nrd; i++)
            chk("R1 read address", 64'(obs_rd[i]), 64'(exp_rd[i]));
        chk(exp_wb ? "R7 write count" : "R8 write count", 64'(obs_nwb), 64'(exp_wb));
        if (exp_wb && obs_nwb == 1) begin
            chk("R7 write address", 64'(obs_wba), 64'(exp_wba));
            chk("R7 write data", obs_wbd, exp_wbd);
        end
        @(negedge clk);
        chk("R9 pulse end", 64'(rsp_valid), 64'd0);
        chk("R9 ready again", 64'(req_ready), 64'd1);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 4096; i++) begin
            mem[i] = {$urandom, $urandom};
            mem[i][0] = (($urandom % 8) != 0);
        end
    endtask

    // Build a present chain through pages 1..4 ending in the given leaf.
    task automatic set_chain(input logic [47:0] va, input logic [63:0] leaf);
        mem[{3'd1, va[47:39]}] = (64'd2 << 12) | 64'd1;
        mem[{3'd2, va[38:30]}] = (64'd3 << 12) | 64'd1;
        mem[{3'd3, va[29:21]}] = (64'd4 << 12) | 64'd1;
        mem[{3'd4, va[20:12]}] = leaf;
    endtask

    localparam logic [63:0] LF = 64'h0000_0123_4567_8000;

    initial begin
        logic [47:0] va;
        void'($urandom(32'd20240611));
        fill_random();
        obs_nrd = 0; obs_nwb = 0;
        fork responder(); join_none
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ready", 64'(req_ready), 64'd1);
        chk("R12 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12 mem_req_valid", 64'(mem_req_valid), 64'd0);

        // root at reset value 0
        do_txn(48'h0000_0040_1234, 2'd0, 1'b0, "R11 reset root");
        set_root(40'd1);
        va = {9'd5, 9'd17, 9'd300, 9'd511, 12'hABC};

        set_chain(va, LF | 64'h7);
        do_txn(va, 2'd0, 1'b1, "R11 loaded root R2");
        do_txn(va, 2'd0, 1'b1, "R8 no change R2");
        do_txn(va, 2'd1, 1'b0, "R7 dirty R2");
        do_txn(va, 2'd1, 1'b1, "R8 write again R2");

        set_chain(va, LF | 64'h5);
        do_txn(va, 2'd1, 1'b1, "R4 read only");
        set_chain(va, LF | 64'h8000_0000_0000_0007);
        do_txn(va, 2'd2, 1'b0, "R5 fetch nx");
        do_txn(va, 2'd0, 1'b0, "R5 read nx");
        set_chain(va, LF | 64'h3);
        do_txn(va, 2'd0, 1'b1, "R6 user on supervisor");
        do_txn(va, 2'd2, 1'b0, "R6 supervisor ok");
        set_chain(va, LF | 64'h8000_0000_0000_0002);
        do_txn(va, 2'd1, 1'b1, "R10 absent wins");
        set_chain(va, LF | 64'h7);
        mem[{3'd3, va[29:21]}] = (64'd4 << 12);
        do_txn(va, 2'd0, 1'b0, "R3 absent level 2");

        for (int t = 0; t < 400; t++) begin
            if (t % 50 == 0) begin
                fill_random();
                set_root(40'($urandom));
            end
            do_txn({$urandom, 16'($urandom)}, 2'($urandom % 3), 1'($urandom), "R2 R3 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule